// File: doc/BRIEF.md
# Stack-Pointer Store Address Unit

This block computes the address, data and stack-pointer update for a store of a 24-bit register through the stack pointer. It supports three addressing modes: post-increment, post-decrement and pre-decrement. The step size is either a default of four bytes or an immediate. That immediate is built from one or two prefix words that arrive in earlier cycles. The source value is widened to a 32-bit word whose top byte is zero. The write request and the stack-pointer write-back leave the block together, one cycle after the store request.

A prefix accumulator holds the immediate bits until the next instruction uses them. Any instruction that is not a prefix empties the accumulator, so an old immediate cannot reach a later store. A store in a branch delay slot ignores a pending immediate and uses the default step. If the effective address is not word aligned, the block raises a one-cycle exception pulse. The write still goes out, with the two low address bits cleared.

Top module: `sp_store_agu`

## Requirements
- R1: The write data is the 24-bit source value zero-extended to 32 bits, so bits 31:24 of `mem_wdata` are always 0.
- R2: Mode code 0 is post-increment: the write address is the current SP, and the new SP is SP plus the step.
- R3: Mode code 1 is post-decrement: the write address is the current SP, and the new SP is SP minus the step.
- R4: Mode code 2 is pre-decrement: the new SP is SP minus the step, and the write goes to that reduced address.
- R5: With no pending prefix, the step is 4 in every mode.
- R6: After a single prefix, the step is that prefix's 13-bit immediate, zero-extended to 24 bits.
- R7: After two prefixes, the step is {bits 10:0 of the first prefix, the 13 bits of the second prefix}. Bits 12:11 of the first prefix are discarded.
- R8: A store flagged as a delay-slot instruction ignores any pending prefix and uses step 4. The pending prefix is still discarded, so a later store also uses step 4.
- R9: When bits 1:0 of the effective address are non-zero, `misalign_exc` pulses with the write. The write still happens, at the effective address with bits 1:0 cleared. `sp_wdata` carries the unaligned value.
- R10: A store request or a non-prefix instruction (`other_valid`) clears the prefix accumulator. A prefix presented in the same cycle as either of them is dropped.
- R11: `mem_we`, `sp_we` and `misalign_exc` are low after reset. `mem_we` and `sp_we` pulse together for exactly one cycle, one clock after an accepted store request.
- R12: SP arithmetic wraps modulo 2^24.
- R13: Mode code 3 is reserved. Such a request produces no write, no SP update and no exception, but it still clears the prefix accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store instruction issued this cycle |
| req_mode | input | 2 | Addressing mode code (0 post-inc, 1 post-dec, 2 pre-dec, 3 reserved) |
| req_delay_slot | input | 1 | Store sits in a branch delay slot |
| req_src | input | 24 | Source register value |
| sp_in | input | 24 | Current stack pointer |
| pfx_valid | input | 1 | Prefix word issued this cycle |
| pfx_imm | input | 13 | Immediate bits carried by the prefix |
| other_valid | input | 1 | Some other non-prefix instruction issued this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Word-aligned write address |
| mem_wdata | output | 32 | Write data |
| sp_we | output | 1 | Stack-pointer write enable |
| sp_wdata | output | 24 | New stack-pointer value |
| misalign_exc | output | 1 | Misaligned-address exception pulse |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 11-bit and 13-bit prefix fields, a 32-bit data word and a step of 4. With these values, the top SP values and SP zero are reachable, so wrap-around in both directions can be tested. A two-prefix immediate can set bit 23 of the step. A single 13-bit prefix can show whether zero-extension leaks into the upper field.

// File: rtl/sp_agu_pkg.sv
package sp_agu_pkg;

  typedef enum logic [1:0] {
    SPM_POST_INC = 2'd0,
    SPM_POST_DEC = 2'd1,
    SPM_PRE_DEC  = 2'd2,
    SPM_RSVD     = 2'd3
  } spm_mode_e;

  localparam int unsigned SPM_MODE_W = 2;

endpackage

// File: rtl/sp_pfx_accum.sv
module sp_pfx_accum #(
  parameter int unsigned HI_W = 11,
  parameter int unsigned LO_W = 13,
  localparam int unsigned IMM_W = HI_W + LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pfx_valid,
  input  logic [LO_W-1:0]  pfx_imm,
  input  logic             consume,
  output logic             pfx_present,
  output logic [IMM_W-1:0] pfx_value
);

  logic [IMM_W-1:0] acc_q;
  logic             present_q;
  logic             ev_pfx_load;

  // a prefix only counts when no consuming instruction shares its cycle
  assign ev_pfx_load = pfx_valid && !consume;

  // shift: the older prefix keeps its low HI_W bits as the upper field
  function automatic logic [IMM_W-1:0] f_shift_in(input logic [IMM_W-1:0] cur,
                                                  input logic [LO_W-1:0]  nxt);
    return {cur[HI_W-1:0], nxt};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      present_q <= 1'b0;
    end else if (consume) begin
      acc_q     <= '0;
      present_q <= 1'b0;
    end else if (ev_pfx_load) begin
      acc_q     <= f_shift_in(acc_q, pfx_imm);
      present_q <= 1'b1;
    end
  end

  assign pfx_present = present_q;
  assign pfx_value   = acc_q;

  AST_PFX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> (!pfx_present && pfx_value == '0)); // R10

  AST_PFX_FIRST_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pfx_load && !pfx_present) |=> (pfx_value[IMM_W-1:LO_W] == '0)); // R6

  AST_PFX_SECOND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pfx_load |=> (pfx_value[LO_W-1:0] == $past(pfx_imm))); // R7

endmodule

// File: rtl/sp_addr_calc.sv
module sp_addr_calc
  import sp_agu_pkg::*;
#(
  parameter int unsigned AW     = 24,
  parameter int unsigned SRC_W  = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STEP   = 4
) (
  input  spm_mode_e         mode,
  input  logic              delay_slot,
  input  logic              pfx_present,
  input  logic [AW-1:0]     pfx_value,
  input  logic [AW-1:0]     sp_cur,
  input  logic [SRC_W-1:0]  src,
  output logic              mode_ok,
  output logic [AW-1:0]     step,
  output logic [AW-1:0]     eff_addr,
  output logic [AW-1:0]     sp_next,
  output logic [DATA_W-1:0] wdata,
  output logic              misaligned
);

  localparam int unsigned BYTES      = DATA_W / 8;
  localparam int unsigned ALIGN_BITS = $clog2(BYTES);
  localparam int unsigned PAD_W      = DATA_W - SRC_W;

  function automatic logic [AW-1:0] f_step(input logic use_pfx,
                                           input logic [AW-1:0] imm);
    return use_pfx ? imm : AW'(STEP);
  endfunction

  function automatic logic [AW-1:0] f_sp_add(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [AW-1:0] f_sp_sub(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    return a - b;
  endfunction

  function automatic logic [DATA_W-1:0] f_pack(input logic [SRC_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  function automatic logic f_misal(input logic [AW-1:0] a);
    return |a[ALIGN_BITS-1:0];
  endfunction

  logic          use_pfx;
  logic [AW-1:0] sp_dec;
  logic [AW-1:0] sp_inc;

  assign use_pfx = pfx_present && !delay_slot;
  assign step    = f_step(use_pfx, pfx_value);
  assign sp_inc  = f_sp_add(sp_cur, step);
  assign sp_dec  = f_sp_sub(sp_cur, step);
  assign wdata   = f_pack(src);

  always_comb begin
    mode_ok  = 1'b1;
    eff_addr = sp_cur;
    sp_next  = sp_cur;
    unique case (mode)
      SPM_POST_INC: begin
        eff_addr = sp_cur;
        sp_next  = sp_inc;
      end
      SPM_POST_DEC: begin
        eff_addr = sp_cur;
        sp_next  = sp_dec;
      end
      SPM_PRE_DEC: begin
        eff_addr = sp_dec;
        sp_next  = sp_dec;
      end
      default: begin
        mode_ok  = 1'b0;
      end
    endcase
  end

  assign misaligned = mode_ok && f_misal(eff_addr);

endmodule

// File: rtl/sp_store_out.sv
module sp_store_out #(
  parameter int unsigned AW     = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SRC_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [AW-1:0]     eff_addr,
  input  logic [AW-1:0]     sp_next,
  input  logic [DATA_W-1:0] wdata,
  input  logic              misaligned,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              sp_we,
  output logic [AW-1:0]     sp_wdata,
  output logic              misalign_exc
);

  localparam int unsigned ALIGN_BITS = $clog2(DATA_W / 8);

  logic [AW-1:0] addr_forced;

  generate
    if (ALIGN_BITS > 0) begin : g_force
      assign addr_forced = {eff_addr[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end else begin : g_pass
      assign addr_forced = eff_addr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we       <= 1'b0;
      sp_we        <= 1'b0;
      misalign_exc <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      sp_wdata     <= '0;
    end else begin
      mem_we       <= fire;
      sp_we        <= fire;
      misalign_exc <= fire && misaligned;
      if (fire) begin
        mem_addr  <= addr_forced;
        mem_wdata <= wdata;
        sp_wdata  <= sp_next;
      end
    end
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ALIGN_BITS-1:0] == '0)); // R9

  AST_EXC_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_exc |-> (mem_we && sp_we)); // R9

  AST_DATA_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[DATA_W-1:SRC_W] == '0)); // R1

  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $rose(sp_we)); // R11

endmodule

// File: rtl/sp_store_agu.sv
module sp_store_agu
  import sp_agu_pkg::*;
#(
  parameter int unsigned AW     = 24,
  parameter int unsigned HI_W   = 11,
  parameter int unsigned LO_W   = 13,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic              req_delay_slot,
  input  logic [AW-1:0]     req_src,
  input  logic [AW-1:0]     sp_in,
  input  logic              pfx_valid,
  input  logic [LO_W-1:0]   pfx_imm,
  input  logic              other_valid,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              sp_we,
  output logic [AW-1:0]     sp_wdata,
  output logic              misalign_exc
);

  localparam int unsigned IMM_W      = HI_W + LO_W;
  localparam int unsigned ALIGN_BITS = $clog2(DATA_W / 8);

  // named internal events
  logic             ev_consume;
  logic             ev_store_fire;
  logic             ev_mode_ok;
  logic             ev_misaligned;
  logic             pfx_present;
  logic [IMM_W-1:0] pfx_raw;
  logic [AW-1:0]    pfx_value;
  logic [AW-1:0]    step;
  logic [AW-1:0]    eff_addr;
  logic [AW-1:0]    sp_next;
  logic [DATA_W-1:0] wdata;
  spm_mode_e        mode;

  assign mode       = spm_mode_e'(req_mode);
  assign ev_consume = req_valid || other_valid;

  generate
    if (IMM_W >= AW) begin : g_imm_trunc
      assign pfx_value = pfx_raw[AW-1:0];
    end else begin : g_imm_ext
      assign pfx_value = {{(AW-IMM_W){1'b0}}, pfx_raw};
    end
  endgenerate

  sp_pfx_accum #(.HI_W(HI_W), .LO_W(LO_W)) u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .pfx_valid   (pfx_valid),
    .pfx_imm     (pfx_imm),
    .consume     (ev_consume),
    .pfx_present (pfx_present),
    .pfx_value   (pfx_raw)
  );

  sp_addr_calc #(.AW(AW), .SRC_W(AW), .DATA_W(DATA_W), .STEP(STEP)) u_calc (
    .mode        (mode),
    .delay_slot  (req_delay_slot),
    .pfx_present (pfx_present),
    .pfx_value   (pfx_value),
    .sp_cur      (sp_in),
    .src         (req_src),
    .mode_ok     (ev_mode_ok),
    .step        (step),
    .eff_addr    (eff_addr),
    .sp_next     (sp_next),
    .wdata       (wdata),
    .misaligned  (ev_misaligned)
  );

  assign ev_store_fire = req_valid && ev_mode_ok;

  sp_store_out #(.AW(AW), .DATA_W(DATA_W), .SRC_W(AW)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (ev_store_fire),
    .eff_addr     (eff_addr),
    .sp_next      (sp_next),
    .wdata        (wdata),
    .misaligned   (ev_misaligned),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .sp_we        (sp_we),
    .sp_wdata     (sp_wdata),
    .misalign_exc (misalign_exc)
  );

  AST_WRITE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store_fire |=> (mem_we && sp_we)); // R11

  AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_store_fire |=> (!mem_we && !sp_we && !misalign_exc)); // R13

  AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_store_fire && mode != SPM_PRE_DEC) |=>
      (mem_addr[AW-1:ALIGN_BITS] == $past(sp_in[AW-1:ALIGN_BITS]))); // R2

  AST_PRE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_store_fire && mode == SPM_PRE_DEC) |=>
      (mem_addr[AW-1:ALIGN_BITS] == sp_wdata[AW-1:ALIGN_BITS])); // R4

  AST_DEFAULT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_store_fire && mode == SPM_POST_INC && (req_delay_slot || !pfx_present)) |=>
      (sp_wdata == $past(sp_in) + AW'(STEP))); // R5

  AST_DATA_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store_fire |=> (mem_wdata[AW-1:0] == $past(req_src))); // R1

endmodule

// File: tb/sp_store_agu_tb.sv
module sp_store_agu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_mode = 2'd0;
  logic        req_delay_slot = 1'b0;
  logic [23:0] req_src = '0;
  logic [23:0] sp_in = '0;
  logic        pfx_valid = 1'b0;
  logic [12:0] pfx_imm = '0;
  logic        other_valid = 1'b0;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        sp_we;
  logic [23:0] sp_wdata;
  logic        misalign_exc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  sp_store_agu dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_delay_slot(req_delay_slot), .req_src(req_src), .sp_in(sp_in),
    .pfx_valid(pfx_valid), .pfx_imm(pfx_imm), .other_valid(other_valid),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .misalign_exc(misalign_exc)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_pfx(input logic [12:0] imm);
    @(negedge clk);
    pfx_valid = 1'b1; pfx_imm = imm;
    @(negedge clk);
    pfx_valid = 1'b0;
  endtask

  task automatic pulse_other();
    @(negedge clk);
    other_valid = 1'b1;
    @(negedge clk);
    other_valid = 1'b0;
  endtask

  task automatic run_store(input string req, input logic [1:0] m, input logic ds,
                           input logic [23:0] src, input logic [23:0] sp,
                           input logic [23:0] exp_addr, input logic [23:0] exp_sp,
                           input logic exp_exc);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_delay_slot = ds; req_src = src; sp_in = sp;
    @(negedge clk);
    req_valid = 1'b0; req_delay_slot = 1'b0;
    chk(req, "mem_we", 32'(mem_we), 32'd1);
    chk(req, "sp_we", 32'(sp_we), 32'd1);
    chk(req, "mem_addr", 32'(mem_addr), 32'(exp_addr));
    chk(req, "sp_wdata", 32'(sp_wdata), 32'(exp_sp));
    chk("R1", "mem_wdata", mem_wdata, {8'h00, src});
    chk(req, "misalign_exc", 32'(misalign_exc), 32'(exp_exc));
    @(negedge clk);
    chk("R11", "mem_we drop", 32'(mem_we), 32'd0);
    chk("R11", "sp_we drop", 32'(sp_we), 32'd0);
    chk("R11", "exc drop", 32'(misalign_exc), 32'd0);
  endtask

  task automatic t_reset();
    chk("R11", "reset mem_we", 32'(mem_we), 32'd0);
    chk("R11", "reset sp_we", 32'(sp_we), 32'd0);
    chk("R11", "reset exc", 32'(misalign_exc), 32'd0);
  endtask

  task automatic t_default_steps();
    run_store("R2", 2'd0, 1'b0, 24'hABCDEF, 24'h000100, 24'h000100, 24'h000104, 1'b0);
    run_store("R3", 2'd1, 1'b0, 24'h123456, 24'h000200, 24'h000200, 24'h0001FC, 1'b0);
    run_store("R4", 2'd2, 1'b0, 24'hFFFFFF, 24'h000200, 24'h0001FC, 24'h0001FC, 1'b0);
    run_store("R5", 2'd1, 1'b0, 24'h000001, 24'h001000, 24'h001000, 24'h000FFC, 1'b0);
  endtask

  task automatic t_single_prefix();
    push_pfx(13'h1FFF);
    run_store("R6", 2'd1, 1'b0, 24'h55AA55, 24'h010000, 24'h010000, 24'h00E001, 1'b0);
    push_pfx(13'h0010);
    run_store("R6", 2'd0, 1'b0, 24'h0F0F0F, 24'h000400, 24'h000400, 24'h000410, 1'b0);
  endtask

  task automatic t_two_prefix();
    // step = {0x123, 0x0004} = 0x246004 (bits 12:11 of 0x1923 dropped)
    push_pfx(13'h1923);
    push_pfx(13'h0004);
    run_store("R7", 2'd2, 1'b0, 24'hC0FFEE, 24'h800000, 24'h5B9FFC, 24'h5B9FFC, 1'b0);
  endtask

  task automatic t_delay_slot();
    push_pfx(13'h0100);
    run_store("R8", 2'd1, 1'b1, 24'h111111, 24'h000300, 24'h000300, 24'h0002FC, 1'b0);
    run_store("R8", 2'd0, 1'b0, 24'h222222, 24'h000300, 24'h000300, 24'h000304, 1'b0);
  endtask

  task automatic t_clear_by_other();
    push_pfx(13'h0040);
    pulse_other();
    run_store("R10", 2'd0, 1'b0, 24'h333333, 24'h000000, 24'h000000, 24'h000004, 1'b0);
    // prefix in the same cycle as another instruction is dropped
    @(negedge clk);
    pfx_valid = 1'b1; pfx_imm = 13'h0080; other_valid = 1'b1;
    @(negedge clk);
    pfx_valid = 1'b0; other_valid = 1'b0;
    run_store("R10", 2'd0, 1'b0, 24'h444444, 24'h000010, 24'h000010, 24'h000014, 1'b0);
  endtask

  task automatic t_misaligned();
    push_pfx(13'h0002);
    run_store("R9", 2'd2, 1'b0, 24'h666666, 24'h000100, 24'h0000FC, 24'h0000FE, 1'b1);
    run_store("R9", 2'd0, 1'b0, 24'h777777, 24'h000103, 24'h000100, 24'h000107, 1'b1);
  endtask

  task automatic t_wrap();
    run_store("R12", 2'd0, 1'b0, 24'h888888, 24'hFFFFFC, 24'hFFFFFC, 24'h000000, 1'b0);
    run_store("R12", 2'd2, 1'b0, 24'h999999, 24'h000000, 24'hFFFFFC, 24'hFFFFFC, 1'b0);
  endtask

  task automatic t_reserved();
    push_pfx(13'h0040);
    @(negedge clk);
    req_valid = 1'b1; req_mode = 2'd3; req_src = 24'hAAAAAA; sp_in = 24'h000501;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13", "mem_we", 32'(mem_we), 32'd0);
    chk("R13", "sp_we", 32'(sp_we), 32'd0);
    chk("R13", "exc", 32'(misalign_exc), 32'd0);
    run_store("R13", 2'd0, 1'b0, 24'hBBBBBB, 24'h000000, 24'h000000, 24'h000004, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_default_steps();
    t_single_prefix();
    t_two_prefix();
    t_delay_slot();
    t_clear_by_other();
    t_misaligned();
    t_wrap();
    t_reserved();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule